// File: doc/BRIEF.md
# Streaming Binary Morphology Filter

This block applies erosion or dilation to a stream of one-bit pixels that arrives in raster order. Every output pixel is decided from a square window centred on the same position. Erosion uses a 3x3 window, and the output pixel is 1 only when all nine window pixels are 1. Dilation uses a 5x5 window, and the output pixel is 1 when any of its twenty-five window pixels is 1. Any window position that falls outside the image counts as 0.

Pixels move through the block in one shift line. The line is deep enough to hold four lines plus four pixels, which covers the 5x5 window; erosion taps a shallower part of it. The operation is selected once per frame, at the pixel that carries the start-of-frame marker. Both sides use valid/ready handshakes. After the last input pixel, the block pushes zero pixels through itself until the remaining outputs have drained. The frame size is fixed by parameters and defaults to 320 by 200.

Top module: `morph_stream`

## Requirements
- R1: With `dilate`=0 latched for the frame, each output pixel is the AND of the 3x3 input neighbourhood centred on it, and positions outside the image count as 0. As a result, every border pixel comes out 0.
- R2: With `dilate`=1 latched for the frame, each output pixel is the OR of the 5x5 input neighbourhood centred on it, and positions outside the image contribute 0.
- R3: `dilate` is sampled only when a start-of-frame pixel is accepted. Changing it later in the frame does not change that frame's result.
- R4: While idle, `in_ready` is 1. A frame starts on an accepted pixel with `in_sof`=1, and that pixel is the frame's first pixel. Pixels accepted while idle with `in_sof`=0 are discarded and have no effect on any output.
- R5: Each frame produces exactly W*H output transfers in raster order. `out_sof` is 1 on the first transfer only. `out_eol` is 1 exactly on the transfers in column W-1.
- R6: The first output of a frame is presented in the same cycle that the input pixel at raster index r*W+r is offered, where r is 1 for erosion and 2 for dilation. That means exactly r*W+r input pixels have been accepted before it.
- R7: When `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. No pixel is lost or repeated under any mix of input gaps and output stalls.
- R8: After the last input pixel of a frame, `in_ready` stays 0 while the remaining outputs drain without further input. The block then returns to idle with `in_ready`=1 and `out_valid`=0.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dilate | input | 1 | Operation select: 1 = 5x5 dilation, 0 = 3x3 erosion. Sampled at frame start |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts the input pixel |
| in_pix | input | 1 | Input pixel value |
| in_sof | input | 1 | Marks the first pixel of a frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | 1 | Output pixel value |
| out_sof | output | 1 | Marks the first output pixel of a frame |
| out_eol | output | 1 | Marks the last output pixel of each line |

## Verification
An all-ones frame under erosion shows whether the border is forced to 0 while the interior stays 1. Isolated set pixels under dilation, one of them in a corner, show whether the 5x5 square is placed and clipped correctly. Dense random frames are run with the operation select flipped after the first pixel. Because erosion and dilation give very different results on dense data, these frames reveal whether the select was re-sampled mid-frame. Random frames with input gaps and output stalls, together with stray non-start pixels offered while idle, test lossless backpressure, the start condition and the latency in each mode.

// File: rtl/morph_stream.sv
module morph_stream #(
  parameter int W = 320,
  parameter int H = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dilate,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_pix,
  input  logic in_sof,
  output logic out_valid,
  input  logic out_ready,
  output logic out_pix,
  output logic out_sof,
  output logic out_eol
);
  localparam int NPIX = W * H;
  localparam int DL   = 4 * W + 4;
  localparam int SW   = $clog2(NPIX + 2 * W + 4);
  localparam int CW   = $clog2(W);

  logic          active, mode_q;
  logic [SW-1:0] s;
  logic [CW-1:0] c;
  logic [DL-1:0] dl;
  logic [CW-1:0] ox;
  logic          er, di;

  wire [SW-1:0] lat     = mode_q ? SW'(2 * W + 2) : SW'(W + 1);
  wire          real_px = s < SW'(NPIX);
  wire          emit    = s >= lat;
  wire          last    = s == SW'(NPIX) + lat - SW'(1);
  wire          newpix  = real_px & in_pix;
  wire          feed    = real_px ? in_valid : 1'b1;
  wire [DL:0]   tap     = {dl, newpix};
  wire          step    = active & feed & (~emit | out_ready);
  wire          start   = ~active & in_valid & in_sof;

  assign in_ready  = ~active | (real_px & (~emit | out_ready));
  assign out_valid = active & emit & feed;
  assign out_pix   = mode_q ? di : er;
  assign out_sof   = emit & (s == lat);
  assign out_eol   = ox == CW'(W - 1);

  always_comb begin
    int r;
    r = mode_q ? 2 : 1;
    if (int'(c) >= r) ox = CW'(int'(c) - r);
    else              ox = CW'(int'(c) + W - r);
  end

  always_comb begin
    er = 1'b1;
    for (int j = -1; j <= 1; j++)
      for (int i = -1; i <= 1; i++)
        er &= tap[(1 - j) * W + (1 - i)] & (int'(ox) + i >= 0) & (int'(ox) + i < W);
    di = 1'b0;
    for (int j = -2; j <= 2; j++)
      for (int i = -2; i <= 2; i++)
        di |= tap[(2 - j) * W + (2 - i)] & (int'(ox) + i >= 0) & (int'(ox) + i < W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      mode_q <= 1'b0;
      s      <= '0;
      c      <= '0;
    end else if (start) begin
      active <= 1'b1;
      mode_q <= dilate;
      s      <= SW'(1);
      c      <= CW'(1);
    end else if (step) begin
      s <= s + SW'(1);
      c <= (c == CW'(W - 1)) ? '0 : c + CW'(1);
      if (last) active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start)     dl <= DL'(in_pix);
    else if (step) dl <= {dl[DL-2:0], newpix};
  end
endmodule

module morph_stream_chk #(
  parameter int W = 320
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_pix,
  input logic out_sof,
  input logic out_eol,
  input logic active,
  input logic mode_q,
  input logic real_px
);
  localparam int CW = $clog2(W);
  logic [CW-1:0] ocol;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocol <= '0;
      seen <= 1'b0;
    end else if (out_valid && out_ready) begin
      seen <= 1'b1;
      if (out_sof)                  ocol <= CW'(1);
      else if (ocol == CW'(W - 1))  ocol <= '0;
      else                          ocol <= ocol + CW'(1);
    end
  end

  AST_STALL_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);  // R7
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    active && !real_px && out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_eol));  // R7
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> !active || $stable(mode_q));  // R3
  AST_EOL_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && seen && !out_sof |-> out_eol == (ocol == CW'(W - 1)));  // R5
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> in_ready && !out_valid);  // R4
  AST_DRAIN_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    active && !real_px |-> !in_ready);  // R8
endmodule

bind morph_stream morph_stream_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pix(out_pix), .out_sof(out_sof), .out_eol(out_eol),
  .active(active), .mode_q(mode_q), .real_px(real_px)
);

// File: tb/morph_stream_tb_top.sv
`timescale 1ns/1ps
module morph_stream_tb_top;
  localparam int W = 8, H = 6, N = W * H;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dilate = 1'b0, in_valid = 1'b0, in_pix = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_pix, out_sof, out_eol;
  bit   img [N];
  int   n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  morph_stream #(.W(W), .H(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .dilate(dilate), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .out_sof(out_sof), .out_eol(out_eol)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit ref_px(input bit dil, input int x, input int y);
    int r = dil ? 2 : 1;
    bit acc = !dil;
    for (int dy = -r; dy <= r; dy++)
      for (int dx = -r; dx <= r; dx++) begin
        bit v = 1'b0;
        if (x + dx >= 0 && x + dx < W && y + dy >= 0 && y + dy < H) v = img[(y + dy) * W + x + dx];
        if (dil) acc |= v; else acc &= v;
      end
    return acc;
  endfunction

  task automatic run_frame(input bit dil, input bit flip, input int gap, input int stall);
    int ii = 0, oo = 0, cyc = 0, lat = -1, bad_px = 0, bad_mk = 0, bad_fl = 0, bad_st = 0;
    int fx = -1, fa = 0, fe = 0;
    string rq = dil ? "R2" : "R1";
    while (oo < N && cyc < 4000) begin
      @(negedge clk);
      if (ii < N) begin
        in_valid = ($urandom_range(99) >= gap);
        in_pix   = img[ii];
        in_sof   = (ii == 0);
      end else begin
        in_valid = 1'b0;
        in_sof   = 1'b0;
      end
      dilate    = (flip && ii > 0) ? !dil : dil;
      out_ready = ($urandom_range(99) >= stall);
      #1;
      if (out_valid && !out_ready && in_ready) bad_st++;
      if (out_valid) begin
        if (lat < 0) lat = ii;
        if (out_ready) begin
          bit e = ref_px(dil, oo % W, oo / W);
          if (out_pix != e) begin
            if (fx < 0) begin fx = oo; fa = out_pix; fe = e; end
            bad_px++;
          end
          if (out_sof != (oo == 0) || out_eol != (oo % W == W - 1)) bad_mk++;
          oo++;
        end
      end
      if (ii >= N && in_ready) bad_fl++;
      if (in_valid && in_ready) ii++;
      cyc++;
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
    chk(oo == N, "R5", "output transfer count", oo, N);
    chk(bad_px == 0, rq, $sformatf("pixel mismatches (first at index %0d, got %0d exp %0d)", fx, fa, fe), bad_px, 0);
    if (flip) chk(bad_px == 0, "R3", "mode change mid-frame altered result", bad_px, 0);
    chk(bad_mk == 0, "R5", "sof/eol marker errors", bad_mk, 0);
    chk(lat == (dil ? 2 * W + 2 : W + 1), "R6", "inputs accepted before first output", lat, dil ? 2 * W + 2 : W + 1);
    chk(bad_st == 0, "R7", "in_ready high while output stalled", bad_st, 0);
    chk(bad_fl == 0, "R8", "in_ready high during drain", bad_fl, 0);
    @(negedge clk); #1;
    chk(in_ready && !out_valid, "R8", "idle after drain (in_ready,out_valid)", {in_ready, out_valid}, 2);
  endtask

  task automatic t_erode_ones();
    foreach (img[k]) img[k] = 1'b1;
    run_frame(1'b0, 1'b0, 0, 0);  // R1 border cleared
  endtask

  task automatic t_dilate_points();
    foreach (img[k]) img[k] = 1'b0;
    img[2 * W + 4] = 1'b1;
    img[0] = 1'b1;
    run_frame(1'b1, 1'b0, 0, 0);  // R2 clipped squares
  endtask

  task automatic t_random(input bit dil, input int dens, input bit flip, input int gap, input int stall);
    foreach (img[k]) img[k] = ($urandom_range(99) < dens);
    run_frame(dil, flip, gap, stall);
  endtask

  task automatic t_idle_discard();
    int bad = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_pix = 1'b1; in_sof = 1'b0; out_ready = 1'b1;
      #1;
      if (!in_ready || out_valid) bad++;
    end
    in_valid = 1'b0;
    chk(bad == 0, "R4", "idle handshake on non-start pixels", bad, 0);
    foreach (img[k]) img[k] = 1'b0;
    run_frame(1'b1, 1'b0, 0, 0);  // R4 discarded ones must not show up
  endtask

  initial begin
    #500000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready && !out_valid, "R9", "reset state (in_ready,out_valid)", {in_ready, out_valid}, 2);
    rst_n = 1'b1;
    t_erode_ones();
    t_dilate_points();
    t_random(1'b0, 75, 1'b0, 30, 40);
    t_random(1'b1, 15, 1'b0, 25, 50);
    t_random(1'b0, 85, 1'b1, 10, 20);
    t_random(1'b1, 10, 1'b1, 10, 20);
    t_idle_discard();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule